// File: doc/BRIEF.md
# Scaled Window Coordinate Walker

This block steps through a rectangular output window in raster order, one pixel per valid/ready handshake. For every output pixel it reports which source-buffer position should be sampled. Each axis has its own fixed-point accumulator, and that accumulator advances by the reciprocal of the wanted scale ratio for each output pixel. A step larger than one shrinks the image. A step smaller than one enlarges it.

Software supplies two 32-bit configuration words, then pulses `start_i`. The scale word holds one step per axis. The crop word holds a source origin and an output window size, both counted in blocks of `BLK_N` pixels. The walker captures both words when the start is accepted. It emits source integer coordinates, 12-bit fractional phases and output counters, and it marks the last pixel of each line and of the frame. When the frame completes it pulses `done_o`. A downstream fetch or interpolation stage consumes these coordinates.

Top module: `scale_coord_gen`

## Requirements
- R1: After reset, `valid_o`, `done_o`, `busy_o`, `eol_o` and `eof_o` are all low.
- R2: The scale word carries the X step in bits 14:0 and the Y step in bits 30:16. Both are unsigned with 12 fraction bits, so 0x1000 means 1.0. Bits 15 and 31 have no effect on any output.
- R3: The crop word is decoded as source X origin in bits 31:24, source Y origin in bits 23:16, output width in bits 15:8 and output height in bits 7:0. All four fields count blocks of `BLK_N` pixels.
- R4: The first output pixel of a frame, at output (0,0), reports source position (XORG·BLK_N, YORG·BLK_N) with both fractional phases zero.
- R5: For output column ox, the reported source X equals XORG·BLK_N·4096 + ox·step_x. `src_x_o` carries the bits above the 12-bit fraction, truncated to `INT_W` bits, and `frac_x_o` carries the low 12 bits.
- R6: For output row oy, the reported source Y equals YORG·BLK_N·4096 + oy·step_y, split into integer and fraction in the same way as X.
- R7: Pixels are emitted in raster order. `out_x_o` runs from 0 to WIDTH·BLK_N−1 within each row, and rows run from 0 to HEIGHT·BLK_N−1. The frame holds exactly WIDTH·BLK_N·HEIGHT·BLK_N handshakes.
- R8: While `valid_o` is high and `ready_i` is low, every output holds its value.
- R9: `eol_o` is high exactly on the valid pixel with the last column. `eof_o` is high exactly on the valid pixel with the last column of the last row.
- R10: `busy_o` is high from the cycle after an accepted start until the final handshake. `done_o` is a one-cycle pulse in the cycle after the final handshake, and `valid_o` is low in that cycle.
- R11: A start with either step zero, or with width or height zero, emits no pixel. `done_o` pulses in the next cycle.
- R12: A start pulse while a frame is in progress is ignored. The running frame continues with its captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse, accepted only when idle |
| scale_i | input | 32 | Per-axis reciprocal scale steps |
| crop_i | input | 32 | Source origin and output window size |
| ready_i | input | 1 | Consumer accepts the current pixel |
| valid_o | output | 1 | Coordinate outputs hold a pixel |
| src_x_o | output | INT_W | Source X integer part |
| src_y_o | output | INT_W | Source Y integer part |
| frac_x_o | output | 12 | Source X fractional phase |
| frac_y_o | output | 12 | Source Y fractional phase |
| out_x_o | output | CNT_W | Output column |
| out_y_o | output | CNT_W | Output row |
| eol_o | output | 1 | Last pixel of a row |
| eof_o | output | 1 | Last pixel of the frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete pulse |

## Verification
The assertions assume that `ready_i` and `start_i` are clean and synchronous. They also assume the configuration words are stable in the cycle where a start is accepted, and are free to change after that. The bench changes `scale_i` and `crop_i` only between frames, with one exception: in the cycles of a deliberate mid-frame start it loads a different crop word, so that R12 can show the captured copy is used. The random window sizes are kept to at most three blocks per axis, and the steps range over the whole 15-bit field, including values with the ignored bits 15 and 31 set. This keeps every source position inside the 16-bit integer width.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int FRAC_W  = 12;
  localparam int SCALE_W = 15;
  localparam int FIELD_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } scg_state_e;
endpackage

// File: rtl/scg_axis_acc.sv
module scg_axis_acc
  import scg_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int BLK_N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 step_en_i,
  input  logic [FIELD_W-1:0]   base_i,
  input  logic [SCALE_W-1:0]   step_i,
  output logic [INT_W-1:0]     int_o,
  output logic [FRAC_W-1:0]    frac_o
);
  localparam int ACC_W = INT_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] origin;

  assign origin = (ACC_W'(base_i) * ACC_W'(BLK_N)) << FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (load_i)    acc_q <= origin;
    else if (step_en_i) acc_q <= acc_q + ACC_W'(step_i);
  end

  assign int_o  = acc_q[ACC_W-1:FRAC_W];
  assign frac_o = acc_q[FRAC_W-1:0];

  // R4
  origin_frac_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> frac_o == '0);
endmodule

// File: rtl/scg_raster_ctl.sv
module scg_raster_ctl #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] x_last_i,
  input  logic [CNT_W-1:0] y_last_i,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o,
  output logic             line_end_o,
  output logic             frame_end_o
);
  logic [CNT_W-1:0] x_q, y_q;

  assign line_end_o  = (x_q == x_last_i);
  assign frame_end_o = line_end_o && (y_q == y_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (clr_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv_i) begin
      if (line_end_o) begin
        x_q <= '0;
        y_q <= y_q + CNT_W'(1);
      end else begin
        x_q <= x_q + CNT_W'(1);
      end
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  // R7
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && line_end_o && !clr_i) |=> x_q == '0);
endmodule

// File: rtl/scale_coord_gen.sv
module scale_coord_gen
  import scg_pkg::*;
#(
  parameter int BLK_N = 8,
  parameter int INT_W = 16,
  localparam int CNT_W = FIELD_W + $clog2(BLK_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [31:0]        scale_i,
  input  logic [31:0]        crop_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [INT_W-1:0]   src_x_o,
  output logic [INT_W-1:0]   src_y_o,
  output logic [FRAC_W-1:0]  frac_x_o,
  output logic [FRAC_W-1:0]  frac_y_o,
  output logic [CNT_W-1:0]   out_x_o,
  output logic [CNT_W-1:0]   out_y_o,
  output logic               eol_o,
  output logic               eof_o,
  output logic               busy_o,
  output logic               done_o
);
  scg_state_e state_q;

  logic [SCALE_W-1:0] step_x_q, step_y_q;
  logic [FIELD_W-1:0] org_x_q, org_y_q;
  logic [CNT_W-1:0]   x_last_q, y_last_q;

  logic [SCALE_W-1:0] in_step_x, in_step_y;
  logic [FIELD_W-1:0] in_org_x, in_org_y, in_w, in_h;
  logic               launch, degenerate, fire, line_end, frame_end;

  // field positions fixed by the crop/scale word layout
  assign in_step_x = scale_i[14:0];
  assign in_step_y = scale_i[30:16];
  assign in_org_x  = crop_i[31:24];
  assign in_org_y  = crop_i[23:16];
  assign in_w      = crop_i[15:8];
  assign in_h      = crop_i[7:0];

  assign launch     = (state_q == ST_IDLE) && start_i;
  assign degenerate = (in_step_x == '0) || (in_step_y == '0) || (in_w == '0) || (in_h == '0);
  assign valid_o    = (state_q == ST_RUN);
  assign fire       = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_x_q <= '0;
      step_y_q <= '0;
      org_x_q  <= '0;
      org_y_q  <= '0;
      x_last_q <= '0;
      y_last_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          step_x_q <= in_step_x;
          step_y_q <= in_step_y;
          org_x_q  <= in_org_x;
          org_y_q  <= in_org_y;
          x_last_q <= CNT_W'(in_w) * CNT_W'(BLK_N) - CNT_W'(1);
          y_last_q <= CNT_W'(in_h) * CNT_W'(BLK_N) - CNT_W'(1);
          state_q  <= degenerate ? ST_DONE : ST_RUN;
        end
        ST_RUN:  if (fire && frame_end) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  scg_raster_ctl #(.CNT_W(CNT_W)) u_raster (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (launch),
    .adv_i       (fire),
    .x_last_i    (x_last_q),
    .y_last_i    (y_last_q),
    .x_o         (out_x_o),
    .y_o         (out_y_o),
    .line_end_o  (line_end),
    .frame_end_o (frame_end)
  );

  scg_axis_acc #(.INT_W(INT_W), .BLK_N(BLK_N)) u_acc_x (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (launch || (fire && line_end)),
    .step_en_i (fire),
    .base_i    (launch ? in_org_x : org_x_q),
    .step_i    (step_x_q),
    .int_o     (src_x_o),
    .frac_o    (frac_x_o)
  );

  scg_axis_acc #(.INT_W(INT_W), .BLK_N(BLK_N)) u_acc_y (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (launch),
    .step_en_i (fire && line_end),
    .base_i    (in_org_y),
    .step_i    (step_y_q),
    .int_o     (src_y_o),
    .frac_o    (frac_y_o)
  );

  assign eol_o  = valid_o && line_end;
  assign eof_o  = valid_o && frame_end;
  assign busy_o = valid_o;
  assign done_o = (state_q == ST_DONE);

  // R8
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(src_x_o) && $stable(frac_x_o)
                               && $stable(src_y_o) && $stable(out_x_o) && $stable(out_y_o)));
  // R9
  eof_in_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> eol_o);
  // R10
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && ready_i) |=> (done_o && !valid_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  ignore_busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i && !ready_i) |=> (valid_o && $stable(out_x_o) && $stable(src_x_o)));
endmodule

// File: tb/tb_scale_coord_gen.sv
module tb_scale_coord_gen;
  localparam int N    = 8;
  localparam int IW   = 16;
  localparam int CW   = 8 + $clog2(N);

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, ready_i = 1'b0;
  logic [31:0] scale_i = '0, crop_i = '0;
  logic valid_o, eol_o, eof_o, busy_o, done_o;
  logic [IW-1:0] src_x_o, src_y_o;
  logic [11:0] frac_x_o, frac_y_o;
  logic [CW-1:0] out_x_o, out_y_o;

  int tests = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  scale_coord_gen #(.BLK_N(N), .INT_W(IW)) dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint pos(input int base, input int idx, input int step);
    return (longint'(base) * N * 4096) + longint'(idx) * step;
  endfunction

  // walk one frame; stall_pct = chance of ready low; poke = pixel index of a mid-frame start
  task automatic run_frame(input logic [31:0] sc, input logic [31:0] cr,
                           input int stall_pct, input int poke);
    int sx = sc[14:0], sy = sc[30:16];
    int bx = cr[31:24], by = cr[23:16], w = cr[15:8] * N, h = cr[7:0] * N;
    int ox = 0, oy = 0, cnt = 0, guard = 0;
    longint ex, ey;
    bit ok;
    @(negedge clk_i);
    scale_i = sc; crop_i = cr; start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    if (sx == 0 || sy == 0 || w == 0 || h == 0) begin
      // R11
      check(done_o && !valid_o, "R11", "degenerate done", {done_o, valid_o}, 2'b10);
      @(negedge clk_i);
      check(!done_o && !valid_o && !busy_o, "R11", "idle after", {done_o, valid_o}, 0);
      return;
    end
    while (!done_o && guard < 20000) begin
      guard++;
      ex = pos(bx, ox, sx);
      ey = pos(by, oy, sy);
      ok = valid_o && busy_o && (src_x_o == ex[27:12]) && (frac_x_o == ex[11:0])
           && (src_y_o == ey[27:12]) && (frac_y_o == ey[11:0])
           && (out_x_o == CW'(ox)) && (out_y_o == CW'(oy));
      // R4 R5 R6 R7 R8
      check(ok, "R5/R6", $sformatf("pix(%0d,%0d) x", ox, oy), {src_x_o, frac_x_o}, ex[27:0]);
      // R9
      check(eol_o == (ox == w-1) && eof_o == (ox == w-1 && oy == h-1), "R9", "eol/eof",
            {eol_o, eof_o}, {(ox == w-1), (ox == w-1 && oy == h-1)});
      start_i = (cnt == poke);
      if (cnt == poke) crop_i = 32'h0101_0101;  // R12: new config must not take
      ready_i = (($urandom % 100) >= stall_pct);
      @(posedge clk_i);
      #1;
      start_i = 1'b0;
      if (ready_i) begin
        cnt++;
        if (ox == w-1) begin ox = 0; oy++; end
        else ox++;
      end
      @(negedge clk_i);
    end
    ready_i = 1'b0;
    // R7 R10
    check(cnt == w*h, "R7", "pixel count", cnt, w*h);
    check(done_o && !valid_o, "R10", "done pulse", {done_o, valid_o}, 2'b10);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R10", "done one cycle", {done_o, busy_o}, 0);
  endtask

  initial begin
    #(20 * 195000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE_5EED));
    #45 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(!valid_o && !done_o && !busy_o && !eol_o && !eof_o, "R1", "reset",
          {valid_o, done_o, busy_o, eol_o, eof_o}, 0);
    // R2 R3 directed: 1:1, 2x, 1/2x, 8/5 with origin
    run_frame(32'h1000_1000, 32'h0000_0101, 0, -1);
    run_frame(32'h0800_0800, 32'h0203_0201, 30, -1);
    run_frame(32'h2000_2000, 32'h0502_0102, 20, -1);
    run_frame(32'h0A00_0400, 32'h0101_0101, 10, -1);
    // R2: bits 15 and 31 set must give the same walk
    run_frame(32'h9000_8800, 32'h0304_0101, 25, -1);
    // R12: start mid-frame
    run_frame(32'h1800_0C00, 32'h0201_0201, 0, 7);
    // R11 degenerate cases
    run_frame(32'h1000_0000, 32'h0000_0101, 0, -1);
    run_frame(32'h0000_1000, 32'h0000_0101, 0, -1);
    run_frame(32'h1000_1000, 32'h0000_0001, 0, -1);
    run_frame(32'h1000_1000, 32'h0000_0100, 0, -1);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] sc, cr;
      sc = $urandom;
      sc[14:0]  = 15'($urandom_range(1, 32767));
      sc[30:16] = 15'($urandom_range(1, 32767));
      cr = {8'($urandom % 8), 8'($urandom % 8), 8'($urandom_range(1, 3)), 8'($urandom_range(1, 3))};
      run_frame(sc, cr, $urandom % 50, (i % 4 == 0) ? 3 : -1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule